// File: doc/BRIEF.md
# Inter-processor word mailbox

The mailbox passes 32-bit words between a host processor and a remote agent through two independent FIFOs. The host writes words into an outbound queue through a push register, and the remote agent drains them through a plain pop port. The remote agent fills an inbound queue through a plain push port, and the host drains it by reading a pop register. All host access goes through a small valid/ready register bus. The block accepts every bus request in the cycle it is offered, and read data is combinational in that cycle.

Three interrupt sources exist. The write-threshold source watches the outbound level. The read-threshold source watches the inbound level. The error source fires on a dropped push or on a pop from an empty queue. Each source has a sticky state bit, an enable bit and a test bit. An interrupt line is asserted while its state bit and its enable bit are both set. Errors are also kept in a separate error register that reading clears.

Top module: `msg_mailbox`

## Requirements
- R1: After reset, status reads 0x1, interrupt state, enable, error and both thresholds read 0, all interrupt lines are low and `out_valid_o` is low.
- R2: Words written to the push register (offset 0x0C) leave on the far-side pop port in write order. `out_data_o` shows the oldest word while `out_valid_o` is high.
- R3: A push while the outbound queue is full is dropped, leaving the queue unchanged. It sets error bit 0 and interrupt state bit 2.
- R4: Reading the pop register (offset 0x10) returns the oldest inbound word and removes it. On an empty queue the read returns 0, sets error bit 1 and sets interrupt state bit 2.
- R5: Status (offset 0x14) has four bits. Bit 0 is inbound empty. Bit 1 is outbound full. Bit 2 is set while the outbound level is above the write threshold. Bit 3 is set while the inbound level is above the read threshold.
- R6: Interrupt state bit 1 sets one cycle after the inbound level exceeds the read threshold (offset 0x20). With a threshold of 0, a single entry sets it. A level equal to the threshold does not set it.
- R7: Interrupt state bit 0 sets one cycle after the outbound level exceeds the write threshold (offset 0x1C).
- R8: Writing 1 to a bit of interrupt state (offset 0x00) clears it. If the bit's condition is true in that same cycle, the bit stays set.
- R9: Each interrupt line equals its state bit ANDed with the matching bit of the enable register (offset 0x04). The lines are bit 0 write-threshold, bit 1 read-threshold and bit 2 error.
- R10: Writing 1 to a bit of the test register (offset 0x08) sets the matching interrupt state bit.
- R11: Error bits (offset 0x18) are sticky until the error register is read. That read returns them and clears them.
- R12: Writing 1 to control bit 0 (offset 0x24) empties the outbound queue, and writing 1 to control bit 1 empties the inbound queue, each at the next edge.
- R13: Both thresholds are 4-bit read/write registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Register request valid |
| bus_ready_o | output | 1 | Request accepted (always high) |
| bus_we_i | input | 1 | Write strobe, 0 for a read |
| bus_addr_i | input | 6 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the request cycle |
| out_data_o | output | 32 | Oldest outbound word |
| out_valid_o | output | 1 | Outbound queue not empty |
| out_pop_i | input | 1 | Far side removes the oldest outbound word |
| in_data_i | input | 32 | Word from far side |
| in_push_i | input | 1 | Far side appends a word to the inbound queue |
| in_full_o | output | 1 | Inbound queue full |
| irq_wthr_o | output | 1 | Write-threshold interrupt |
| irq_rthr_o | output | 1 | Read-threshold interrupt |
| irq_err_o | output | 1 | Error interrupt |

## Verification
Register writes, pushes, pops and flushes take effect at the edge that closes the request cycle, so their results are checked from the next cycle. Error bits and the error interrupt state bit are registered at that same edge. The threshold interrupt state bits lag the level that causes them by one further edge, because the comparison is made on the registered level. The bench therefore inserts one idle cycle before it reads interrupt state after any change of level or threshold. Read data is combinational and is captured one nanosecond after the request is driven on the falling edge. Interrupt lines are sampled just after the rising edge that updates the enable register.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int REG_AW = 6;

  localparam logic [REG_AW-1:0] OFF_ISTATE = 6'h00;
  localparam logic [REG_AW-1:0] OFF_IEN    = 6'h04;
  localparam logic [REG_AW-1:0] OFF_ITEST  = 6'h08;
  localparam logic [REG_AW-1:0] OFF_PUSH   = 6'h0C;
  localparam logic [REG_AW-1:0] OFF_POP    = 6'h10;
  localparam logic [REG_AW-1:0] OFF_STAT   = 6'h14;
  localparam logic [REG_AW-1:0] OFF_ERR    = 6'h18;
  localparam logic [REG_AW-1:0] OFF_WTHR   = 6'h1C;
  localparam logic [REG_AW-1:0] OFF_RTHR   = 6'h20;
  localparam logic [REG_AW-1:0] OFF_CTRL   = 6'h24;

  localparam int IRQ_N   = 3;
  localparam int IRQ_WT  = 0;
  localparam int IRQ_RT  = 1;
  localparam int IRQ_ERR = 2;

  localparam int ERR_N   = 2;
  localparam int ERR_OVF = 0;
  localparam int ERR_UDF = 1;

  localparam int CTRL_FLUSH_OUT = 0;
  localparam int CTRL_FLUSH_IN  = 1;

  typedef struct packed {
    logic rflag;
    logic wflag;
    logic out_full;
    logic in_empty;
  } status_t;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] level_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (level_q == LW'(DEPTH));
  assign empty_o = (level_q == '0);
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  assign rdata_o = mem[rd_ptr_q];
  assign level_o = level_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      level_q <= level_q + LW'(do_push) - LW'(do_pop);
    end
  end
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] test_i,
  input  logic [N-1:0] clr_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_wdata_i,
  output logic [N-1:0] state_o,
  output logic [N-1:0] en_o,
  output logic [N-1:0] irq_o
);
  logic [N-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end
  assign en_o = en_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic st_q;
    // set beats clear so a still-true condition keeps the bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= 1'b0;
      else         st_q <= (st_q & ~clr_i[i]) | set_i[i] | test_i[i];
    end
    assign state_o[i] = st_q;
    assign irq_o[i]   = st_q & en_q[i];
  end
endmodule

// File: rtl/msg_mailbox.sv
module msg_mailbox
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int THR_W  = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  output logic              bus_ready_o,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_valid_o,
  input  logic              out_pop_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_push_i,
  output logic              in_full_o,
  output logic              irq_wthr_o,
  output logic              irq_rthr_o,
  output logic              irq_err_o
);
  logic wr_acc, rd_acc;
  logic push_req, pop_req, err_rd, ctrl_wr;
  logic flush_out, flush_in, ovf, udf;
  logic out_full, out_empty, in_full, in_empty;
  logic [LVL_W-1:0]  out_level, in_level;
  logic [DATA_W-1:0] in_rdata;
  logic [THR_W-1:0]  wthr, rthr;
  logic [ERR_N-1:0]  err_q;
  logic [IRQ_N-1:0]  irq_set, irq_test, irq_clr, istate, ien, irq_vec;
  status_t           stat;

  assign bus_ready_o = 1'b1;
  assign wr_acc = bus_valid_i & bus_we_i;
  assign rd_acc = bus_valid_i & ~bus_we_i;

  assign push_req  = wr_acc & (bus_addr_i == OFF_PUSH);
  assign pop_req   = rd_acc & (bus_addr_i == OFF_POP);
  assign err_rd    = rd_acc & (bus_addr_i == OFF_ERR);
  assign ctrl_wr   = wr_acc & (bus_addr_i == OFF_CTRL);
  assign flush_out = ctrl_wr & bus_wdata_i[CTRL_FLUSH_OUT];
  assign flush_in  = ctrl_wr & bus_wdata_i[CTRL_FLUSH_IN];
  assign ovf       = push_req & out_full;
  assign udf       = pop_req & in_empty;

  mbox_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_out_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_out),
    .push_i  (push_req),
    .wdata_i (bus_wdata_i),
    .pop_i   (out_pop_i),
    .rdata_o (out_data_o),
    .level_o (out_level),
    .full_o  (out_full),
    .empty_o (out_empty)
  );

  mbox_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_in_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_in),
    .push_i  (in_push_i),
    .wdata_i (in_data_i),
    .pop_i   (pop_req),
    .rdata_o (in_rdata),
    .level_o (in_level),
    .full_o  (in_full),
    .empty_o (in_empty)
  );

  assign out_valid_o = ~out_empty;
  assign in_full_o   = in_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wthr <= '0;
      rthr <= '0;
    end else begin
      if (wr_acc && bus_addr_i == OFF_WTHR) wthr <= bus_wdata_i[THR_W-1:0];
      if (wr_acc && bus_addr_i == OFF_RTHR) rthr <= bus_wdata_i[THR_W-1:0];
    end
  end

  // new errors in the read cycle survive the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= '0;
    else         err_q <= (err_rd ? '0 : err_q) | {udf, ovf};
  end

  assign stat.in_empty = in_empty;
  assign stat.out_full = out_full;
  assign stat.wflag    = 32'(out_level) > 32'(wthr);
  assign stat.rflag    = 32'(in_level) > 32'(rthr);

  always_comb begin
    irq_set          = '0;
    irq_set[IRQ_WT]  = stat.wflag;
    irq_set[IRQ_RT]  = stat.rflag;
    irq_set[IRQ_ERR] = ovf | udf;
  end
  assign irq_clr  = (wr_acc && bus_addr_i == OFF_ISTATE) ? bus_wdata_i[IRQ_N-1:0] : '0;
  assign irq_test = (wr_acc && bus_addr_i == OFF_ITEST)  ? bus_wdata_i[IRQ_N-1:0] : '0;

  mbox_irq #(.N(IRQ_N)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (irq_set),
    .test_i     (irq_test),
    .clr_i      (irq_clr),
    .en_we_i    (wr_acc && bus_addr_i == OFF_IEN),
    .en_wdata_i (bus_wdata_i[IRQ_N-1:0]),
    .state_o    (istate),
    .en_o       (ien),
    .irq_o      (irq_vec)
  );

  assign irq_wthr_o = irq_vec[IRQ_WT];
  assign irq_rthr_o = irq_vec[IRQ_RT];
  assign irq_err_o  = irq_vec[IRQ_ERR];

  always_comb begin
    bus_rdata_o = '0;
    if (rd_acc) begin
      unique case (bus_addr_i)
        OFF_ISTATE: bus_rdata_o = DATA_W'(istate);
        OFF_IEN:    bus_rdata_o = DATA_W'(ien);
        OFF_POP:    bus_rdata_o = in_empty ? '0 : in_rdata;
        OFF_STAT:   bus_rdata_o = DATA_W'(stat);
        OFF_ERR:    bus_rdata_o = DATA_W'(err_q);
        OFF_WTHR:   bus_rdata_o = DATA_W'(wthr);
        OFF_RTHR:   bus_rdata_o = DATA_W'(rthr);
        default:    bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int DW    = 32,
  parameter int LW    = 4,
  parameter int THR_W = 4,
  parameter int DEPTH = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          push_req,
  input logic          pop_req,
  input logic          err_rd,
  input logic          flush_out,
  input logic          flush_in,
  input logic          out_pop_i,
  input logic          out_full,
  input logic          in_empty,
  input logic [LW-1:0] out_level,
  input logic [LW-1:0] in_level,
  input logic [THR_W-1:0] wthr,
  input logic [THR_W-1:0] rthr,
  input logic [2:0]    istate,
  input logic [1:0]    err_q,
  input logic [DW-1:0] bus_rdata_o
);
  p_level_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(out_level) <= DEPTH) && (32'(in_level) <= DEPTH));

  p_drop_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req && out_full && !out_pop_i && !flush_out) |=> (out_level == $past(out_level)));

  p_empty_pop_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_req && in_empty) |-> (bus_rdata_o == '0));

  p_rthr_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(in_level) > 32'(rthr)) |=> istate[1]);

  p_wthr_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(out_level) > 32'(wthr)) |=> istate[0]);

  p_err_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_rd |=> ((err_q & $past(err_q)) == $past(err_q)));

  p_flush_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_out |=> (out_level == '0));

  p_flush_in_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_in |=> (in_level == '0));
endmodule

bind msg_mailbox mbox_checker #(
  .DW(DATA_W), .LW(LVL_W), .THR_W(THR_W), .DEPTH(DEPTH)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_req    (push_req),
  .pop_req     (pop_req),
  .err_rd      (err_rd),
  .flush_out   (flush_out),
  .flush_in    (flush_in),
  .out_pop_i   (out_pop_i),
  .out_full    (out_full),
  .in_empty    (in_empty),
  .out_level   (out_level),
  .in_level    (in_level),
  .wthr        (wthr),
  .rthr        (rthr),
  .istate      (istate),
  .err_q       (err_q),
  .bus_rdata_o (bus_rdata_o)
);

// File: tb/sim_msg_mailbox.sv
`timescale 1ns/1ps
module sim_msg_mailbox;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_valid_i = 1'b0;
  logic        bus_ready_o;
  logic        bus_we_i = 1'b0;
  logic [5:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [31:0] out_data_o;
  logic        out_valid_o;
  logic        out_pop_i = 1'b0;
  logic [31:0] in_data_i = '0;
  logic        in_push_i = 1'b0;
  logic        in_full_o;
  logic        irq_wthr_o, irq_rthr_o, irq_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  msg_mailbox u0 (.*);

  always #4 clk_i = ~clk_i;

  typedef struct packed {
    logic        we;
    logic [5:0]  addr;
    logic [31:0] data;
  } vec_t;

  // read entries compare bus data with .data
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'h1C, 32'd2},
    '{1'b0, 6'h1C, 32'd2},
    '{1'b1, 6'h0C, 32'hA1},
    '{1'b1, 6'h0C, 32'hA2},
    '{1'b1, 6'h0C, 32'hA3},
    '{1'b0, 6'h14, 32'h5},
    '{1'b0, 6'h00, 32'h1},
    '{1'b1, 6'h00, 32'h1},
    '{1'b0, 6'h00, 32'h1},
    '{1'b1, 6'h24, 32'h1},
    '{1'b0, 6'h14, 32'h1},
    '{1'b1, 6'h00, 32'h1},
    '{1'b0, 6'h00, 32'h0}
  };
  localparam string VREQ [NV] = '{"R13", "R13", "R2", "R2", "R2", "R5", "R7",
                                  "R8", "R8", "R12", "R12", "R8", "R8"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_valid_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk_i); #1;
    bus_valid_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_valid_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(posedge clk_i); #1;
    bus_valid_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic far_pop();
    @(negedge clk_i);
    out_pop_i = 1'b1;
    @(posedge clk_i); #1;
    out_pop_i = 1'b0;
  endtask

  task automatic far_push(input logic [31:0] d);
    @(negedge clk_i);
    in_push_i = 1'b1; in_data_i = d;
    @(posedge clk_i); #1;
    in_push_i = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(2);
    rst_ni = 1'b1;
    idle(1);

    // R1 reset state
    rd_chk("R1", 6'h14, 32'h1);
    rd_chk("R1", 6'h00, 32'h0);
    rd_chk("R1", 6'h04, 32'h0);
    rd_chk("R1", 6'h18, 32'h0);
    rd_chk("R1", 6'h1C, 32'h0);
    rd_chk("R1", 6'h20, 32'h0);
    chk("R1", {29'd0, irq_err_o, irq_rthr_o, irq_wthr_o}, 32'h0);
    chk("R1", {31'd0, out_valid_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) bus_wr(VECS[i].addr, VECS[i].data);
      else            rd_chk(VREQ[i], VECS[i].addr, VECS[i].data);
    end

    // R2 far-side order
    bus_wr(6'h0C, 32'h11);
    bus_wr(6'h0C, 32'h22);
    chk("R2", {31'd0, out_valid_o}, 32'h1);
    chk("R2", out_data_o, 32'h11);
    far_pop();
    chk("R2", out_data_o, 32'h22);
    far_pop();
    chk("R2", {31'd0, out_valid_o}, 32'h0);

    // R3 overflow drop, R5 full flag, R11 clear on read
    for (int i = 0; i < 8; i++) bus_wr(6'h0C, 32'd100 + 32'(3 * i));
    idle(1);
    rd_chk("R5", 6'h14, 32'h7);
    bus_wr(6'h0C, 32'hDEAD);
    rd_chk("R3", 6'h18, 32'h1);
    rd_chk("R11", 6'h18, 32'h0);
    rd_chk("R3", 6'h00, 32'h5);
    for (int i = 0; i < 8; i++) begin
      chk("R3", out_data_o, 32'd100 + 32'(3 * i));
      far_pop();
    end
    chk("R3", {31'd0, out_valid_o}, 32'h0);
    bus_wr(6'h00, 32'h7);
    rd_chk("R8", 6'h00, 32'h0);

    // R4 pop, R6 read threshold, R9 gating
    far_push(32'h55);
    far_push(32'h66);
    idle(1);
    rd_chk("R6", 6'h00, 32'h2);
    bus_wr(6'h04, 32'h2);
    chk("R9", {29'd0, irq_err_o, irq_rthr_o, irq_wthr_o}, 32'h2);
    rd_chk("R4", 6'h10, 32'h55);
    rd_chk("R4", 6'h10, 32'h66);
    rd_chk("R4", 6'h10, 32'h0);
    rd_chk("R4", 6'h18, 32'h2);
    bus_wr(6'h04, 32'h0);
    chk("R9", {31'd0, irq_rthr_o}, 32'h0);
    bus_wr(6'h00, 32'h7);
    rd_chk("R8", 6'h00, 32'h0);

    // R6 level equal to threshold, R8 re-set while true
    bus_wr(6'h20, 32'h1);
    rd_chk("R13", 6'h20, 32'h1);
    far_push(32'h77);
    idle(1);
    rd_chk("R6", 6'h00, 32'h0);
    bus_wr(6'h20, 32'h0);
    bus_wr(6'h00, 32'h2);
    rd_chk("R8", 6'h00, 32'h2);
    bus_wr(6'h24, 32'h2);
    rd_chk("R12", 6'h14, 32'h1);
    bus_wr(6'h00, 32'h2);
    rd_chk("R8", 6'h00, 32'h0);

    // R10 test register
    bus_wr(6'h08, 32'h4);
    rd_chk("R10", 6'h00, 32'h4);
    bus_wr(6'h04, 32'h4);
    chk("R9", {31'd0, irq_err_o}, 32'h1);
    bus_wr(6'h00, 32'h4);
    rd_chk("R10", 6'h00, 32'h0);
    chk("R9", {31'd0, irq_err_o}, 32'h0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule